// File: doc/BRIEF.md
# Single-Wire Network Addressing Layer

This block is the network-addressing stage of a single-wire slave. It sits above a bit-level slot engine. That engine reports each write slot as a strobe with the sampled bit, each read slot as a strobe, and each line reset as a strobe. After every line reset the layer collects an 8-bit addressing command and then does one of four things:

- transmit the device identity;
- compare an identity sent by the master;
- take part in the bit-wise search arbitration;
- skip addressing altogether.

When addressing succeeds it raises `selected`, which hands the wire to the device function layer. When addressing fails it releases the wire and ignores all slots until the next line reset.

The 64-bit identity is built from two parameters, an 8-bit family byte and a 48-bit serial number. The top byte is a CRC-8 that the layer generates serially while it shifts out or compares the identity bits, so the CRC byte never has to be stored.

Top module: `owAddrLayer`

## Requirements
- R1: After rstN is released, `selected` is 0 and `txBit` is 1 (wire released).
- R2: The command is taken from 8 write slots, least significant bit first. Code 8'h33 makes the next 64 read slots return the identity least significant bit first: bits 0..7 are the family byte (default 8'h24), bits 8..55 are the serial number, and bits 56..63 are the CRC byte. `selected` rises after the 64th read slot.
- R3: The CRC byte is the CRC-8 with polynomial x^8+x^5+x^4+1, computed from a register cleared to zero with the 56 data bits fed least significant bit first. Running the CRC over all 64 identity bits leaves zero.
- R4: Code 8'h55 compares the next 64 write slots against the identity. If all 64 agree, `selected` rises after the 64th slot.
- R5: During the compare, a disagreeing bit ends addressing. `selected` then stays 0 and read slots return 1 until the next line reset.
- R6: Code 8'hF0 starts the search. For each of the 64 bits, in order, a read slot returns the identity bit, a second read slot returns its complement, and a write slot takes the master's choice. If all 64 choices agree, `selected` rises.
- R7: During the search, a master choice that differs from the identity bit drops the device out. `selected` stays 0 and read slots return 1 until the next line reset.
- R8: Code 8'hCC raises `selected` right after the 8th command bit, with no identity exchange.
- R9: Any other command code leaves the device passive. `selected` stays 0 and read slots return 1 until the next line reset.
- R10: A `lineReset` strobe at any point clears `selected` and restarts command reception at bit 0.
- R11: Once `selected` is 1, it holds until a line reset, and `txBit` stays 1 while it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineReset | input | 1 | One-cycle strobe: reset/presence sequence detected on the wire |
| rdSlot | input | 1 | One-cycle strobe: master read slot consumes `txBit` |
| wrSlot | input | 1 | One-cycle strobe: master write slot completed |
| wrBit | input | 1 | Bit sampled in the write slot, valid with `wrSlot` |
| txBit | output | 1 | Bit to present in the next read slot (1 = release) |
| selected | output | 1 | Addressing succeeded; function layer owns the wire |

## Verification
A wrong bit index or a wrong CRC state shows up on `txBit` in the first read slot that uses it, at the latest by bit 63 of the CRC byte. The bench checks every one of the 64 positions. A state that wrongly stays in compare or search, or wrongly leaves it, shows at the ports within one slot: `selected` rises too early or too late, or a dropped-out device still pulls the wire low on a read. Restarts after a line reset are checked by completing a fresh skip command straight after the reset.

// File: rtl/owAddrPkg.sv
package owAddrPkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SBIT,
    ST_SCMP,
    ST_SWR,
    ST_SEL,
    ST_IDLE
  } addrState_t;

  typedef enum logic [1:0] {
    TX_REL,
    TX_TRUE,
    TX_COMP
  } txMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    clear;     // zero bit index and CRC
    logic    cmdShift;  // take one command bit
    logic    advance;   // step to next identity bit
    txMode_t txMode;
  } dpCtl_t;

  localparam logic [7:0] CMD_READ   = 8'h33;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_SEARCH = 8'hF0;
  localparam logic [7:0] CMD_SKIP   = 8'hCC;

endpackage

// File: rtl/owAddrData.sv
module owAddrData
  import owAddrPkg::*;
#(
  parameter int FAM_W = 8,
  parameter int SER_W = 48,
  parameter int CRC_W = 8,
  parameter int CMD_W = 8,
  parameter logic [FAM_W-1:0] FAMILY = 8'h24,
  parameter logic [SER_W-1:0] SERIAL = 48'hA53C0F197E42,
  parameter logic [CRC_W-1:0] POLY_REV = 8'h8C,
  localparam int DATA_W = FAM_W + SER_W,
  localparam int ID_W = DATA_W + CRC_W,
  localparam int IDX_W = $clog2(ID_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             wrBit,
  output logic [CMD_W-2:0] cmdHist,
  output logic             cmdLast,
  output logic             curBit,
  output logic             idLast,
  output logic             txBit
);

  localparam logic [DATA_W-1:0] ID_DATA = {SERIAL, FAMILY};

  logic [IDX_W-1:0] bitIdx;
  logic [CRC_W-1:0] crcReg;

  function automatic logic [CRC_W-1:0] crcStep(logic [CRC_W-1:0] c, logic d);
    logic fb;
    fb = c[0] ^ d;
    return (c >> 1) ^ (fb ? POLY_REV : '0);
  endfunction

  // identity bit: stored data, then CRC shifted out LSB first
  always_comb begin
    if (int'(bitIdx) < DATA_W) curBit = ID_DATA[bitIdx];
    else                       curBit = crcReg[0];
  end

  assign cmdLast = (int'(bitIdx) == CMD_W - 1);
  assign idLast  = (int'(bitIdx) == ID_W - 1);

  always_comb begin
    unique case (ctl.txMode)
      TX_TRUE: txBit = curBit;
      TX_COMP: txBit = ~curBit;
      default: txBit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx  <= '0;
      crcReg  <= '0;
      cmdHist <= '0;
    end else begin
      if (ctl.cmdShift) cmdHist <= {wrBit, cmdHist[CMD_W-2:1]};
      if (ctl.clear) begin
        bitIdx <= '0;
        crcReg <= '0;
      end else if (ctl.cmdShift) begin
        bitIdx <= bitIdx + 1'b1;
      end else if (ctl.advance) begin
        bitIdx <= idLast ? '0 : bitIdx + 1'b1;
        crcReg <= crcStep(crcReg, curBit);
      end
    end
  end

  // R3
  crc_residual_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance && !ctl.clear && idLast |=> crcReg == '0);

endmodule

// File: rtl/owAddrCtrl.sv
module owAddrCtrl
  import owAddrPkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineReset,
  input  logic             rdSlot,
  input  logic             wrSlot,
  input  logic             wrBit,
  input  logic [CMD_W-2:0] cmdHist,
  input  logic             cmdLast,
  input  logic             curBit,
  input  logic             idLast,
  output dpCtl_t           ctl,
  output logic             selected
);

  addrState_t state, stateNext;
  logic [CMD_W-1:0] cmdNow;

  assign cmdNow = {wrBit, cmdHist};
  assign selected = (state == ST_SEL);

  always_comb begin
    stateNext    = state;
    ctl.clear    = 1'b0;
    ctl.cmdShift = 1'b0;
    ctl.advance  = 1'b0;
    ctl.txMode   = TX_REL;
    unique case (state)
      ST_READ: ctl.txMode = TX_TRUE;
      ST_SBIT: ctl.txMode = TX_TRUE;
      ST_SCMP: ctl.txMode = TX_COMP;
      default: ctl.txMode = TX_REL;
    endcase
    if (lineReset) begin
      stateNext = ST_CMD;
      ctl.clear = 1'b1;
    end else begin
      unique case (state)
        ST_CMD: if (wrSlot) begin
          ctl.cmdShift = 1'b1;
          if (cmdLast) begin
            ctl.clear = 1'b1;
            unique case (cmdNow)
              CMD_READ:   stateNext = ST_READ;
              CMD_MATCH:  stateNext = ST_MATCH;
              CMD_SEARCH: stateNext = ST_SBIT;
              CMD_SKIP:   stateNext = ST_SEL;
              default:    stateNext = ST_IDLE;
            endcase
          end
        end
        ST_READ: if (rdSlot) begin
          ctl.advance = 1'b1;
          if (idLast) stateNext = ST_SEL;
        end
        ST_MATCH: if (wrSlot) begin
          if (wrBit != curBit) stateNext = ST_IDLE;
          else begin
            ctl.advance = 1'b1;
            if (idLast) stateNext = ST_SEL;
          end
        end
        ST_SBIT: if (rdSlot) stateNext = ST_SCMP;
        ST_SCMP: if (rdSlot) stateNext = ST_SWR;
        ST_SWR: if (wrSlot) begin
          if (wrBit != curBit) stateNext = ST_IDLE;
          else begin
            ctl.advance = 1'b1;
            stateNext = idLast ? ST_SEL : ST_SBIT;
          end
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CMD;
    else       state <= stateNext;
  end

  // R10
  rst_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineReset |=> state == ST_CMD);

  // R11
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SEL && !lineReset |=> state == ST_SEL);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE && !lineReset |=> state == ST_IDLE);

  // R6
  search_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SCMP && rdSlot && !lineReset |=> state == ST_SWR);

endmodule

// File: rtl/owAddrLayer.sv
module owAddrLayer
  import owAddrPkg::*;
#(
  parameter int FAM_W = 8,
  parameter int SER_W = 48,
  parameter int CRC_W = 8,
  parameter int CMD_W = 8,
  parameter logic [FAM_W-1:0] FAMILY = 8'h24,
  parameter logic [SER_W-1:0] SERIAL = 48'hA53C0F197E42,
  parameter logic [CRC_W-1:0] POLY_REV = 8'h8C
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineReset,
  input  logic rdSlot,
  input  logic wrSlot,
  input  logic wrBit,
  output logic txBit,
  output logic selected
);

  dpCtl_t           ctl;
  logic [CMD_W-2:0] cmdHist;
  logic             cmdLast;
  logic             curBit;
  logic             idLast;

  owAddrCtrl #(.CMD_W(CMD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineReset(lineReset), .rdSlot(rdSlot),
    .wrSlot(wrSlot), .wrBit(wrBit), .cmdHist(cmdHist), .cmdLast(cmdLast),
    .curBit(curBit), .idLast(idLast), .ctl(ctl), .selected(selected)
  );

  owAddrData #(
    .FAM_W(FAM_W), .SER_W(SER_W), .CRC_W(CRC_W), .CMD_W(CMD_W),
    .FAMILY(FAMILY), .SERIAL(SERIAL), .POLY_REV(POLY_REV)
  ) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrBit(wrBit), .cmdHist(cmdHist),
    .cmdLast(cmdLast), .curBit(curBit), .idLast(idLast), .txBit(txBit)
  );

  // R11
  sel_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> txBit);

endmodule

// File: tb/tb_owAddrLayer.sv
module tb_owAddrLayer;

  localparam logic [7:0]  FAM = 8'h24;
  localparam logic [47:0] SER = 48'hA53C0F197E42;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineReset = 1'b0, rdSlot = 1'b0, wrSlot = 1'b0, wrBit = 1'b0;
  logic txBit, selected;
  int total = 0;
  int bad = 0;
  logic [63:0] expId;

  always #5 clk = ~clk;

  owAddrLayer dut (
    .clk(clk), .rstN(rstN), .lineReset(lineReset), .rdSlot(rdSlot),
    .wrSlot(wrSlot), .wrBit(wrBit), .txBit(txBit), .selected(selected)
  );

  function automatic logic [7:0] crcOf(logic [63:0] v, int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb = c[0] ^ v[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseReset();
    @(negedge clk); lineReset = 1'b1;
    @(negedge clk); lineReset = 1'b0;
  endtask

  task automatic writeBit(logic b);
    @(negedge clk); wrBit = b; wrSlot = 1'b1;
    @(negedge clk); wrSlot = 1'b0;
  endtask

  task automatic readBit(output logic b);
    @(negedge clk); b = txBit; rdSlot = 1'b1;
    @(negedge clk); rdSlot = 1'b0;
  endtask

  task automatic writeByte(logic [7:0] v);
    for (int i = 0; i < 8; i++) writeBit(v[i]);
  endtask

  task automatic testResetState();
    check("R1 selected", selected, 0);
    check("R1 txBit", txBit, 1);
  endtask

  task automatic testRead();
    logic [63:0] got;
    logic b;
    pulseReset();
    writeByte(8'h33);
    for (int i = 0; i < 64; i++) begin readBit(b); got[i] = b; end
    check("R2 family", got[7:0], FAM);
    check("R2 serial", got[55:8], SER);
    check("R3 crc byte", got[63:56], crcOf(expId, 56));
    check("R3 residual", crcOf(got, 64), 0);
    @(negedge clk);
    check("R2 selected after read", selected, 1);
    readBit(b);
    check("R11 release while selected", b, 1);
    check("R11 selected holds", selected, 1);
  endtask

  task automatic testSkip();
    pulseReset();
    writeByte(8'hCC);
    @(negedge clk);
    check("R8 skip selects", selected, 1);
    pulseReset();
    @(negedge clk);
    check("R10 reset clears selected", selected, 0);
  endtask

  task automatic testMatch(int badPos);
    logic b;
    pulseReset();
    writeByte(8'h55);
    for (int i = 0; i < 64; i++) begin
      if (i == 63 && badPos < 0) begin
        @(negedge clk);
        check("R4 not early", selected, 0);
      end
      writeBit(i == badPos ? ~expId[i] : expId[i]);
    end
    @(negedge clk);
    if (badPos < 0) check("R4 match selects", selected, 1);
    else begin
      check("R5 mismatch no select", selected, 0);
      readBit(b);
      check("R5 released after mismatch", b, 1);
    end
  endtask

  task automatic testSearch(int badPos);
    logic b, c;
    int errs = 0;
    pulseReset();
    writeByte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      if (i <= badPos || badPos < 0) begin
        readBit(b); readBit(c);
        if (b !== expId[i] || c !== ~expId[i]) errs++;
        writeBit(i == badPos ? ~expId[i] : expId[i]);
      end
    end
    check("R6 search bit/complement", errs, 0);
    @(negedge clk);
    if (badPos < 0) check("R6 search selects", selected, 1);
    else begin
      check("R7 dropout no select", selected, 0);
      readBit(b);
      check("R7 released after dropout", b, 1);
    end
  endtask

  task automatic testUnknown();
    logic b;
    pulseReset();
    writeByte(8'hA5);
    readBit(b);
    check("R9 unknown releases", b, 1);
    writeByte(8'hCC);
    check("R9 unknown stays passive", selected, 0);
  endtask

  task automatic testMidReset();
    logic b;
    pulseReset();
    writeByte(8'h33);
    for (int i = 0; i < 10; i++) readBit(b);
    pulseReset();
    writeBit(1'b0); writeBit(1'b0);
    pulseReset();
    writeByte(8'hCC);
    @(negedge clk);
    check("R10 restart after mid reset", selected, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    expId = {crcOf({8'h00, SER, FAM}, 56), SER, FAM};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testRead();
    testSkip();
    testMatch(-1);
    testMatch(20);
    testSearch(-1);
    testSearch(30);
    testUnknown();
    testMidReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule